// File: doc/BRIEF.md
# Four-Bit Selectable Arithmetic/Logic Slice

A purely combinational four-bit slice that turns two operands into a four-bit result under a four-bit function code and a mode bit. With the mode bit high it applies one of sixteen bitwise Boolean functions, and no carry affects any result bit. With the mode bit low it applies one of sixteen arithmetic functions. Each of these is the sum of two terms built from the operands, plus an optional incoming carry, and the carries are formed by full lookahead inside the slice.

Besides the result, the slice drives a carry output, an all-ones flag and a pair of group signals, propagate and generate, for an outside lookahead unit. Carry input and carry output are active low, so a low carry output means a carry was produced. Slices can be ripple-chained by wiring one slice's carry output to the next slice's carry input. Subtraction is formed by adding the complement, so a produced carry means no borrow.

Top module: `alu4_slice`

## Requirements
- R1: With `logicMode`=1 the result for `funcSel` 0 through 15 is, in that order: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A.
- R2: With `logicMode`=1 the result does not depend on `carryInN`.
- R3: With `logicMode`=0 and `carryInN`=1 the result for `funcSel` 0 through 15 is, in that order, modulo 16: A, A|B, A|~B, minus 1, A+(A&~B), (A|B)+(A&~B), A-B-1, (A&~B)-1, A+(A&B), A+B, (A|~B)+(A&B), (A&B)-1, A+A, (A|B)+A, (A|~B)+A, A-1.
- R4: With `logicMode`=0 and `carryInN`=0 the result is the R3 value plus one, modulo 16.
- R5: Every arithmetic code is the sum of a first term X = A | (funcSel[0] ? B : 0) | (funcSel[1] ? ~B : 0) and a second term Y = (funcSel[2] ? A&~B : 0) | (funcSel[3] ? A&B : 0). In both modes `carryOutN` is 0 exactly when X + Y + (carryInN ? 0 : 1) is at least 16.
- R6: For `funcSel`=6, `logicMode`=0 and `carryInN`=0, the result is A-B modulo 16, and `carryOutN` is 0 exactly when A >= B, which means no borrow.
- R7: `allOnes` is 1 exactly when all four result bits are 1. With `funcSel`=6, `logicMode`=0 and `carryInN`=1 it is therefore 1 exactly when A equals B.
- R8: `grpGen` is 1 exactly when X + Y is at least 16, whatever `carryInN` is. In the add code (`funcSel`=9) this means A+B >= 16.
- R9: `grpProp` is 1 exactly when X is all ones, whatever `carryInN` is. In the add code this means (A|B) = 15. In both modes the produced carry equals `grpGen` | (`grpProp` & carry in).
- R10: With `funcSel`=12, `logicMode`=0 and `carryInN`=1, the result is A shifted one place toward the MSB with a 0 entering bit 0, and `carryOutN` is the inverse of A[3].
- R11: Two slices ripple-chained through carry perform 8-bit addition with `funcSel`=9 and `carryInN`=1. With `funcSel`=6 and `carryInN`=0 they perform 8-bit subtraction, and the final carry marks no borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | Operand A |
| opB | input | 4 | Operand B |
| funcSel | input | 4 | Function code |
| logicMode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carryInN | input | 1 | Incoming carry, active low |
| result | output | 4 | Function result |
| carryOutN | output | 1 | Produced carry, active low |
| allOnes | output | 1 | High when every result bit is 1 |
| grpProp | output | 1 | Group propagate for outside lookahead |
| grpGen | output | 1 | Group generate for outside lookahead |

## Verification
In a single evaluation the slice both resolves the arithmetic result with its carry output and raises the all-ones flag. In the subtract code with no carry applied, these two together express an equal, less-than or greater-than comparison. The bench provokes this by sweeping every operand pair under the subtract code with the carry both inactive and active. It checks that `allOnes` marks exactly the equal pairs and that `carryOutN` marks exactly the pairs with no borrow, while the carry-independent group outputs stay unchanged between the two carry settings.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int WIDTH = 4;

  typedef struct packed {
    logic passB;       // first term takes B
    logic passNotB;    // first term takes ~B
    logic addAndNotB;  // second term takes A&~B
    logic addAnd;      // second term takes A&B
    logic arith;       // carries reach the result
    logic carryIn;     // active-high incoming carry
  } ctrl_t;
endpackage

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic [3:0] funcSel,
  input  logic       logicMode,
  input  logic       carryInN,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl.passB      = funcSel[0];
    ctrl.passNotB   = funcSel[1];
    ctrl.addAndNotB = funcSel[2];
    ctrl.addAnd     = funcSel[3];
    ctrl.arith      = ~logicMode;
    ctrl.carryIn    = ~carryInN;
  end
endmodule

// File: rtl/alu4_datapath.sv
module alu4_datapath
  import alu4_pkg::*;
#(
  parameter int W = WIDTH
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  ctrl_t        ctrl,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic         allOnes,
  output logic         grpProp,
  output logic         grpGen
);
  logic [W-1:0] termX;
  logic [W-1:0] termY;
  logic [W:0]   carry;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign termX[i] = opA[i] | (opB[i] & ctrl.passB) | (~opB[i] & ctrl.passNotB);
    assign termY[i] = (opA[i] & ~opB[i] & ctrl.addAndNotB) | (opA[i] & opB[i] & ctrl.addAnd);
    assign result[i] = ctrl.arith ? (termX[i] ^ termY[i] ^ carry[i])
                                  : ~(termX[i] ^ termY[i]);
  end

  // Full lookahead: every carry is a flat sum of products over lower bits.
  always_comb begin
    carry[0] = ctrl.carryIn;
    for (int i = 1; i <= W; i++) begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = i - 1; j >= 0; j--) begin
        acc = acc | (run & termY[j]);
        run = run & termX[j];
      end
      carry[i] = acc | (run & ctrl.carryIn);
    end
  end

  always_comb begin
    logic g;
    g = 1'b0;
    for (int j = 0; j < W; j++) g = termY[j] | (termX[j] & g);
    grpGen = g;
  end

  assign grpProp  = &termX;
  assign carryOut = carry[W];
  assign allOnes  = &result;
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu4_pkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  input  logic [3:0] funcSel,
  input  logic       logicMode,
  input  logic       carryInN,
  output logic [3:0] result,
  output logic       carryOutN,
  output logic       allOnes,
  output logic       grpProp,
  output logic       grpGen
);
  ctrl_t ctrl;
  logic  carryOut;

  alu4_ctrl u_ctrl (
    .funcSel(funcSel), .logicMode(logicMode), .carryInN(carryInN), .ctrl(ctrl)
  );

  alu4_datapath #(.W(WIDTH)) u_dp (
    .opA(opA), .opB(opB), .ctrl(ctrl), .result(result), .carryOut(carryOut),
    .allOnes(allOnes), .grpProp(grpProp), .grpGen(grpGen)
  );

  assign carryOutN = ~carryOut;
endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk (
  input logic [3:0] opA,
  input logic [3:0] opB,
  input logic [3:0] funcSel,
  input logic       logicMode,
  input logic       carryInN,
  input logic [3:0] result,
  input logic       carryOutN,
  input logic       allOnes,
  input logic       grpProp,
  input logic       grpGen
);
  always_comb begin
    if (logicMode && funcSel == 4'd6)
      AST_LOGIC_XOR: assert (result == (opA ^ opB)); // R1
    if (!logicMode && funcSel == 4'd9)
      AST_ADD_SUM: assert ({~carryOutN, result} == ({1'b0, opA} + {1'b0, opB} + {4'd0, ~carryInN})); // R4
    if (!logicMode && funcSel == 4'd6 && !carryInN)
      AST_SUB_NO_BORROW: assert (~carryOutN == (opA >= opB)); // R6
    if (!logicMode && funcSel == 4'd6 && carryInN)
      AST_EQ_ON_SUB: assert (allOnes == (opA == opB)); // R7
    if (!logicMode && funcSel == 4'd9)
      AST_ADD_GEN: assert (grpGen == (({1'b0, opA} + {1'b0, opB}) >= 5'd16)); // R8
    AST_CARRY_FROM_GROUP: assert (~carryOutN == (grpGen | (grpProp & ~carryInN))); // R9
    if (!logicMode && funcSel == 4'd12 && carryInN)
      AST_SHIFT_UP: assert (result == {opA[2:0], 1'b0} && carryOutN == ~opA[3]); // R10
  end
endmodule

bind alu4_slice alu4_slice_chk u_chk (
  .opA(opA), .opB(opB), .funcSel(funcSel), .logicMode(logicMode), .carryInN(carryInN),
  .result(result), .carryOutN(carryOutN), .allOnes(allOnes), .grpProp(grpProp), .grpGen(grpGen)
);

// File: tb/alu4_slice_bench.sv
module alu4_slice_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] opA, opB, funcSel;
  logic       logicMode, carryInN;
  logic [3:0] result;
  logic       carryOutN, allOnes, grpProp, grpGen;

  alu4_slice u_alu4_slice (
    .opA(opA), .opB(opB), .funcSel(funcSel), .logicMode(logicMode), .carryInN(carryInN),
    .result(result), .carryOutN(carryOutN), .allOnes(allOnes), .grpProp(grpProp), .grpGen(grpGen)
  );

  // Ripple pair for 8-bit work
  logic [7:0] chA, chB;
  logic [3:0] chSel;
  logic       chCinN, midN, chCoutN;
  logic [3:0] loRes, hiRes;
  logic       u1, u2, u3, u4, u5, u6;

  alu4_slice u_chainLo (
    .opA(chA[3:0]), .opB(chB[3:0]), .funcSel(chSel), .logicMode(1'b0), .carryInN(chCinN),
    .result(loRes), .carryOutN(midN), .allOnes(u1), .grpProp(u2), .grpGen(u3)
  );
  alu4_slice u_chainHi (
    .opA(chA[7:4]), .opB(chB[7:4]), .funcSel(chSel), .logicMode(1'b0), .carryInN(midN),
    .result(hiRes), .carryOutN(chCoutN), .allOnes(u4), .grpProp(u5), .grpGen(u6)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (A=%0d B=%0d S=%0d M=%0d CnN=%0d)",
               tag, actual, expected, opA, opB, funcSel, logicMode, carryInN);
    end
  endtask

  function automatic logic [3:0] refLogic(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      4'd0:  return ~a;
      4'd1:  return ~(a | b);
      4'd2:  return ~a & b;
      4'd3:  return 4'h0;
      4'd4:  return ~(a & b);
      4'd5:  return ~b;
      4'd6:  return a ^ b;
      4'd7:  return a & ~b;
      4'd8:  return ~a | b;
      4'd9:  return ~(a ^ b);
      4'd10: return b;
      4'd11: return a & b;
      4'd12: return 4'hF;
      4'd13: return a | ~b;
      4'd14: return a | b;
      default: return a;
    endcase
  endfunction

  // Two addends per arithmetic code, as listed in R3/R5
  task automatic refTerms(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b,
                          output logic [3:0] x, output logic [3:0] y);
    case (s)
      4'd0:  begin x = a;      y = 4'h0;   end
      4'd1:  begin x = a | b;  y = 4'h0;   end
      4'd2:  begin x = a | ~b; y = 4'h0;   end
      4'd3:  begin x = 4'hF;   y = 4'h0;   end
      4'd4:  begin x = a;      y = a & ~b; end
      4'd5:  begin x = a | b;  y = a & ~b; end
      4'd6:  begin x = a | ~b; y = a & ~b; end
      4'd7:  begin x = 4'hF;   y = a & ~b; end
      4'd8:  begin x = a;      y = a & b;  end
      4'd9:  begin x = a | b;  y = a & b;  end
      4'd10: begin x = a | ~b; y = a & b;  end
      4'd11: begin x = 4'hF;   y = a & b;  end
      4'd12: begin x = a;      y = a;      end
      4'd13: begin x = a | b;  y = a;      end
      4'd14: begin x = a | ~b; y = a;      end
      default: begin x = 4'hF; y = a;      end
    endcase
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                       input logic m, input logic cn);
    @(negedge clk);
    opA = a; opB = b; funcSel = s; logicMode = m; carryInN = cn;
    #1;
  endtask

  task automatic testReset();
    apply(4'h0, 4'h0, 4'h0, 1'b1, 1'b1);
    check(result == 4'hF, "R1 idle result", result, 15);
    check(allOnes == 1'b1, "R7 idle allOnes", allOnes, 1);
  endtask

  task automatic testSweep();
    for (int v = 0; v < 16384; v++) begin
      logic [3:0] a, b, s, x, y, expRes;
      logic m, cn;
      logic [4:0] full, pair;
      a = v[3:0]; b = v[7:4]; s = v[11:8]; m = v[12]; cn = v[13];
      refTerms(s, a, b, x, y);
      pair = {1'b0, x} + {1'b0, y};
      full = pair + {4'd0, ~cn};
      if (m) expRes = refLogic(s, a, b);
      else   expRes = full[3:0];
      apply(a, b, s, m, cn);
      if (m) check(result == expRes, "R1 logic result", result, expRes);
      else if (cn) check(result == expRes, "R3 arith result", result, expRes);
      else check(result == expRes, "R4 arith with carry", result, expRes);
      check(carryOutN == ~full[4], "R5 carry out", carryOutN, ~full[4]);
      check(allOnes == (expRes == 4'hF), "R7 allOnes", allOnes, expRes == 4'hF);
      check(grpGen == pair[4], "R8 group generate", grpGen, pair[4]);
      check(grpProp == (x == 4'hF), "R9 group propagate", grpProp, x == 4'hF);
    end
  endtask

  task automatic testLogicIgnoresCarry();
    for (int s = 0; s < 16; s++) begin
      logic [3:0] r1;
      apply(4'hA, 4'h6, s[3:0], 1'b1, 1'b1);
      r1 = result;
      apply(4'hA, 4'h6, s[3:0], 1'b1, 1'b0);
      check(result == r1, "R2 logic carry ignored", result, r1);
    end
  endtask

  task automatic testSubtractCompare();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        logic p0, g0;
        apply(a[3:0], b[3:0], 4'd6, 1'b0, 1'b1);
        check(allOnes == (a == b), "R7 equal under subtract", allOnes, a == b);
        p0 = grpProp; g0 = grpGen;
        apply(a[3:0], b[3:0], 4'd6, 1'b0, 1'b0);
        check(result == 4'((a - b) & 15), "R6 difference", result, (a - b) & 15);
        check(carryOutN == !(a >= b), "R6 no-borrow carry", carryOutN, !(a >= b));
        check(grpProp == p0 && grpGen == g0, "R9 group signals carry-independent",
              {grpProp, grpGen}, {p0, g0});
      end
  endtask

  task automatic testAddGroups();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        apply(a[3:0], b[3:0], 4'd9, 1'b0, 1'b0);
        check(grpGen == (a + b >= 16), "R8 add generate", grpGen, a + b >= 16);
        check(grpProp == ((a | b) == 15), "R9 add propagate", grpProp, (a | b) == 15);
      end
  endtask

  task automatic testShift();
    for (int a = 0; a < 16; a++) begin
      apply(a[3:0], 4'h5, 4'd12, 1'b0, 1'b1);
      check(result == 4'((a << 1) & 15), "R10 shift result", result, (a << 1) & 15);
      check(carryOutN == !a[3], "R10 shift carry", carryOutN, !a[3]);
    end
  endtask

  task automatic testChain();
    for (int a = 0; a < 256; a += 23)
      for (int b = 0; b < 256; b += 29) begin
        @(negedge clk);
        chA = a[7:0]; chB = b[7:0]; chSel = 4'd9; chCinN = 1'b1;
        #1;
        check({hiRes, loRes} == 8'((a + b) & 255), "R11 chained add", {hiRes, loRes}, (a + b) & 255);
        check(chCoutN == !(a + b >= 256), "R11 chained add carry", chCoutN, !(a + b >= 256));
        @(negedge clk);
        chSel = 4'd6; chCinN = 1'b0;
        #1;
        check({hiRes, loRes} == 8'((a - b) & 255), "R11 chained subtract", {hiRes, loRes}, (a - b) & 255);
        check(chCoutN == !(a >= b), "R11 chained borrow", chCoutN, !(a >= b));
      end
  endtask

  initial begin
    opA = '0; opB = '0; funcSel = '0; logicMode = 1'b1; carryInN = 1'b1;
    chA = '0; chB = '0; chSel = 4'd9; chCinN = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testReset();
    testSweep();
    testLogicIgnoresCarry();
    testSubtractCompare();
    testAddGroups();
    testShift();
    testChain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule